// File: doc/BRIEF.md
# Blanking-Interval User Control Capture

This block sits beside the parallel pixel input of a dual-pixel display link transmitter. It picks up two user-defined control bits, called E and F here, from two spare positions of the second-pixel blue input. Sampling happens only during the vertical-sync low period. The block holds the last sampled pair while vertical sync is high, and it presents the pair for insertion on two serial data lanes whenever the link is blanking. All state advances only on cycles where the pixel clock enable is high.

A matching receiver-side register is part of the same block. It watches the recovered vertical sync and data-enable signals. During blanking cycles inside the vertical-sync low window, it reloads the recovered lane bits into two held control outputs. The whole feature is live only when the link runs dual-pixel and DC-balanced. Outside that mode, every output of the feature is driven low. The reset input is asynchronous and active low, and its release is synchronised to the clock.

Top module: `uctl_blank_capture`

## Requirements
- R1: On the enabled cycle where vsync is first seen low after being seen high (a falling edge), nothing is captured, and ctl_e/ctl_f keep their previous values.
- R2: On each later enabled cycle while vsync stays low, ctl_e and ctl_f take the input values of that cycle, visible after the clock edge.
- R3: While vsync is high, ctl_e and ctl_f hold the last value captured, until the next low period has passed its falling-edge cycle.
- R4: ctl_e is taken from blue2_in bit 7 and ctl_f from blue2_in bit 6. No other blue2_in bit affects any output.
- R5: lane_ins_en is high exactly when the mode is active and de is low. lane_ins_bits[0] (lane 4) carries ctl_e and lane_ins_bits[1] (lane 5) carries ctl_f while lane_ins_en is high. Both bits are 0 otherwise.
- R6: The mode is active only when mode_dual and mode_dcbal are both 1. While it is inactive, ctl_e, ctl_f, rx_ctl_e, rx_ctl_f and lane_ins_en are all 0, and no capture takes place. The pair held before the mode went inactive reappears when the mode returns.
- R7: On an enabled cycle with the mode active, rx_de low and rx_vsync low past its own falling-edge cycle, rx_ctl_e takes rx_lane4 and rx_ctl_f takes rx_lane5.
- R8: On every other cycle, rx_ctl_e and rx_ctl_f keep their value. This includes active-video cycles (rx_de high), rx_vsync high, and the rx falling-edge cycle.
- R9: Asserting rst_n clears all held values to 0 at once. Both sync histories are preset to high, so the first enabled cycle after release that sees vsync low counts as a falling edge. The block leaves reset on the second clock edge after rst_n rises.
- R10: On cycles where pix_en is low, no held value and no sync history changes, so a vsync pulse that spans only such cycles goes unseen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable; state advances only when high |
| mode_dual | input | 1 | Dual-pixel link mode selected |
| mode_dcbal | input | 1 | DC-balanced link mode selected |
| vsync | input | 1 | Transmit-side vertical sync |
| de | input | 1 | Transmit-side data enable (low means blanking) |
| blue2_in | input | BLUE_W | Second-pixel blue input; bits 7 and 6 carry E and F |
| lane_ins_en | output | 1 | Insert control bits on lanes 4 and 5 this cycle |
| lane_ins_bits | output | 2 | Bit 0 for lane 4 (E), bit 1 for lane 5 (F) |
| ctl_e | output | 1 | Held transmit-side control E |
| ctl_f | output | 1 | Held transmit-side control F |
| rx_vsync | input | 1 | Recovered vertical sync |
| rx_de | input | 1 | Recovered data enable |
| rx_lane4 | input | 1 | Recovered blanking bit from lane 4 (E) |
| rx_lane5 | input | 1 | Recovered blanking bit from lane 5 (F) |
| rx_ctl_e | output | 1 | Held receiver-side control E |
| rx_ctl_f | output | 1 | Held receiver-side control F |

## Verification
The hardest case to reach is a falling edge of vsync that coincides with a gated pixel-enable cycle or with a mode change. In that case the edge history, the capture gate and the mode gate all interact in one cycle. The sweep drives vsync, pix_en, de and both mode bits from counters of coprime periods, so these alignments occur many times across 256 blue values. A second reset with vsync already low covers the preset edge history.

// File: rtl/uctl_pkg.sv
package uctl_pkg;

  typedef struct packed {
    logic e;
    logic f;
  } uctl_pair_t;

  localparam int unsigned UCTL_PATHS = 2;
  localparam int unsigned UCTL_TX    = 0;
  localparam int unsigned UCTL_RX    = 1;

endpackage

// File: rtl/uctl_rst_sync.sv
module uctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  always_comb begin
    rst_core_n = chain_q[STAGES-1];
  end

endmodule

// File: rtl/uctl_vs_window.sv
module uctl_vs_window (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic vs,
  output logic hist,
  output logic strobe
);

  logic hist_d;

  always_comb begin
    hist_d = hist;
    if (en) begin
      hist_d = vs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= 1'b1;
    end else begin
      hist <= hist_d;
    end
  end

  // open window: low now, and already low at the previous enabled cycle
  always_comb begin
    strobe = en && !vs && !hist;
  end

endmodule

// File: rtl/uctl_pair_hold.sv
module uctl_pair_hold
  import uctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  uctl_pair_t d,
  output uctl_pair_t q
);

  uctl_pair_t q_d;

  always_comb begin
    q_d = q;
    if (load) begin
      q_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/uctl_blank_capture.sv
module uctl_blank_capture
  import uctl_pkg::*;
#(
  parameter int unsigned BLUE_W      = 8,
  parameter int unsigned E_POS       = 7,
  parameter int unsigned F_POS       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              mode_dual,
  input  logic              mode_dcbal,
  input  logic              vsync,
  input  logic              de,
  input  logic [BLUE_W-1:0] blue2_in,
  output logic              lane_ins_en,
  output logic [1:0]        lane_ins_bits,
  output logic              ctl_e,
  output logic              ctl_f,
  input  logic              rx_vsync,
  input  logic              rx_de,
  input  logic              rx_lane4,
  input  logic              rx_lane5,
  output logic              rx_ctl_e,
  output logic              rx_ctl_f
);

  localparam int unsigned NP = UCTL_PATHS;

  logic rst_core_n;
  logic mode_on;
  logic unused_blue;

  logic [NP-1:0] vs_arr;
  logic [NP-1:0] gap_arr;
  logic [NP-1:0] win_hist;
  logic [NP-1:0] win_strobe;
  logic [NP-1:0] load_arr;
  uctl_pair_t    pair_d [NP];
  uctl_pair_t    pair_q [NP];

  logic tx_hist;
  logic rx_hist;

  uctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  always_comb begin
    mode_on     = mode_dual && mode_dcbal;
    unused_blue = ^blue2_in;
  end

  // path sources: transmit samples every window cycle, receive only in blanking
  always_comb begin
    vs_arr[UCTL_TX]   = vsync;
    vs_arr[UCTL_RX]   = rx_vsync;
    gap_arr[UCTL_TX]  = 1'b1;
    gap_arr[UCTL_RX]  = !rx_de;
    pair_d[UCTL_TX].e = blue2_in[E_POS];
    pair_d[UCTL_TX].f = blue2_in[F_POS];
    pair_d[UCTL_RX].e = rx_lane4;
    pair_d[UCTL_RX].f = rx_lane5;
  end

  for (genvar g = 0; g < NP; g++) begin : g_path
    uctl_vs_window u_win (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .en     (pix_en),
      .vs     (vs_arr[g]),
      .hist   (win_hist[g]),
      .strobe (win_strobe[g])
    );

    always_comb begin
      load_arr[g] = mode_on && win_strobe[g] && gap_arr[g];
    end

    uctl_pair_hold u_hold (
      .clk   (clk),
      .rst_n (rst_core_n),
      .load  (load_arr[g]),
      .d     (pair_d[g]),
      .q     (pair_q[g])
    );
  end

  always_comb begin
    tx_hist       = win_hist[UCTL_TX];
    rx_hist       = win_hist[UCTL_RX];
    ctl_e         = mode_on && pair_q[UCTL_TX].e;
    ctl_f         = mode_on && pair_q[UCTL_TX].f;
    rx_ctl_e      = mode_on && pair_q[UCTL_RX].e;
    rx_ctl_f      = mode_on && pair_q[UCTL_RX].f;
    lane_ins_en   = mode_on && !de;
    lane_ins_bits = lane_ins_en ? {pair_q[UCTL_TX].f, pair_q[UCTL_TX].e} : 2'b00;
  end

endmodule

// File: rtl/uctl_blank_capture_chk.sv
module uctl_blank_capture_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       pix_en,
  input logic       mode_dual,
  input logic       mode_dcbal,
  input logic       vsync,
  input logic       de,
  input logic       blue_e,
  input logic       blue_f,
  input logic       tx_hist,
  input logic       rx_vsync,
  input logic       rx_de,
  input logic       rx_lane4,
  input logic       rx_lane5,
  input logic       rx_hist,
  input logic       ctl_e,
  input logic       ctl_f,
  input logic       rx_ctl_e,
  input logic       rx_ctl_f,
  input logic       lane_ins_en,
  input logic [1:0] lane_ins_bits
);

  logic mode_on;
  always_comb mode_on = mode_dual && mode_dcbal;

  AST_FALL_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_on && pix_en && !vsync && tx_hist) |=> (!mode_on || $stable({ctl_e, ctl_f}))); // R1

  AST_WINDOW_SAMPLE: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_on && pix_en && !vsync && !tx_hist) |=> (!mode_on || ({ctl_e, ctl_f} == $past({blue_e, blue_f})))); // R2

  AST_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_on && (vsync || !pix_en)) |=> (!mode_on || $stable({ctl_e, ctl_f}))); // R3

  AST_NO_INSERT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_ok)
    de |-> (!lane_ins_en && lane_ins_bits == 2'b00)); // R5

  AST_INSERT_MATCH: assert property (@(posedge clk) disable iff (!rst_ok)
    lane_ins_en |-> (lane_ins_bits == {ctl_f, ctl_e})); // R5

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    !mode_on |-> (!ctl_e && !ctl_f && !rx_ctl_e && !rx_ctl_f && !lane_ins_en)); // R6

  AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_on && pix_en && !rx_de && !rx_vsync && !rx_hist) |=>
      (!mode_on || ({rx_ctl_e, rx_ctl_f} == $past({rx_lane4, rx_lane5})))); // R7

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_on && (rx_de || rx_vsync || rx_hist || !pix_en)) |=> (!mode_on || $stable({rx_ctl_e, rx_ctl_f}))); // R8

  AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_ok)
    !pix_en |=> ($stable(tx_hist) && $stable(rx_hist))); // R10

endmodule

bind uctl_blank_capture uctl_blank_capture_chk u_chk (
  .clk           (clk),
  .rst_ok        (rst_core_n),
  .pix_en        (pix_en),
  .mode_dual     (mode_dual),
  .mode_dcbal    (mode_dcbal),
  .vsync         (vsync),
  .de            (de),
  .blue_e        (blue2_in[E_POS]),
  .blue_f        (blue2_in[F_POS]),
  .tx_hist       (tx_hist),
  .rx_vsync      (rx_vsync),
  .rx_de         (rx_de),
  .rx_lane4      (rx_lane4),
  .rx_lane5      (rx_lane5),
  .rx_hist       (rx_hist),
  .ctl_e         (ctl_e),
  .ctl_f         (ctl_f),
  .rx_ctl_e      (rx_ctl_e),
  .rx_ctl_f      (rx_ctl_f),
  .lane_ins_en   (lane_ins_en),
  .lane_ins_bits (lane_ins_bits)
);

// File: tb/uctl_blank_capture_test.sv
module uctl_blank_capture_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b1;
  logic       mode_dual = 1'b1;
  logic       mode_dcbal = 1'b1;
  logic       vsync = 1'b1;
  logic       de = 1'b0;
  logic [7:0] blue2_in = 8'h00;
  logic       lane_ins_en;
  logic [1:0] lane_ins_bits;
  logic       ctl_e, ctl_f;
  logic       rx_vsync = 1'b1;
  logic       rx_de = 1'b0;
  logic       rx_lane4 = 1'b0;
  logic       rx_lane5 = 1'b0;
  logic       rx_ctl_e, rx_ctl_f;

  int checks = 0;
  int failures = 0;

  // bench model, built from the requirements
  logic       m_hist = 1'b1;
  logic       m_rhist = 1'b1;
  logic [1:0] m_cap = 2'b00;   // {e, f}
  logic [1:0] m_rx = 2'b00;    // {e, f}
  int         rst_hold = 2;

  always #2.5 clk = ~clk;

  uctl_blank_capture uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .mode_dual(mode_dual), .mode_dcbal(mode_dcbal),
    .vsync(vsync), .de(de), .blue2_in(blue2_in), .lane_ins_en(lane_ins_en),
    .lane_ins_bits(lane_ins_bits), .ctl_e(ctl_e), .ctl_f(ctl_f), .rx_vsync(rx_vsync),
    .rx_de(rx_de), .rx_lane4(rx_lane4), .rx_lane5(rx_lane5), .rx_ctl_e(rx_ctl_e), .rx_ctl_f(rx_ctl_f)
  );

  task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string ttag, input string rtag);
    logic mon;
    logic len;
    mon = mode_dual && mode_dcbal;
    len = mon && !de;
    chk(ttag, "ctl_e/ctl_f", {2'b00, ctl_e, ctl_f}, {2'b00, (mon ? m_cap : 2'b00)});
    chk("R5", "lane insert", {1'b0, lane_ins_en, lane_ins_bits},
        {1'b0, len, (len ? {m_cap[0], m_cap[1]} : 2'b00)});
    chk(rtag, "rx_ctl_e/rx_ctl_f", {2'b00, rx_ctl_e, rx_ctl_f}, {2'b00, (mon ? m_rx : 2'b00)});
  endtask

  task automatic tick();
    string tt;
    string tr;
    logic  mon;
    mon = mode_dual && mode_dcbal;
    if (!rst_n) begin
      m_hist = 1'b1; m_rhist = 1'b1; m_cap = 2'b00; m_rx = 2'b00; rst_hold = 2;
      tt = "R9"; tr = "R9";
    end else if (rst_hold > 0) begin
      rst_hold--;
      tt = "R9"; tr = "R9";
    end else begin
      if (!mon) tt = "R6";
      else if (!pix_en) tt = "R10";
      else if (!vsync && m_hist) tt = "R1";
      else if (!vsync) tt = "R2";
      else tt = "R3";
      tr = "R8";
      if (pix_en) begin
        if (mon && !vsync && !m_hist) m_cap = {blue2_in[7], blue2_in[6]};
        if (mon && !rx_vsync && !m_rhist && !rx_de) begin
          m_rx = {rx_lane4, rx_lane5};
          tr = "R7";
        end
        m_hist = vsync;
        m_rhist = rx_vsync;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tt, tr);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    // R9: reset state
    repeat (3) tick();
    chk("R9", "ctl during reset", {2'b00, ctl_e, ctl_f}, 4'h0);
    rst_n = 1'b1;
    repeat (4) tick();

    // near-exhaustive sweep over the blue input with coprime control patterns
    for (int v = 0; v < 256; v++) begin
      blue2_in   = v[7:0];
      vsync      = (v % 9) < 3;
      pix_en     = (v % 7) != 6;
      de         = (v % 5) == 0;
      rx_vsync   = (v % 11) < 4;
      rx_de      = (v % 3) == 0;
      rx_lane4   = v[1];
      rx_lane5   = v[2];
      mode_dual  = !(v >= 100 && v < 120);
      mode_dcbal = !(v >= 180 && v < 195);
      tick();
    end

    // R4: only bits 7 and 6 matter
    mode_dual = 1'b1; mode_dcbal = 1'b1; pix_en = 1'b1; de = 1'b0;
    vsync = 1'b1; tick();
    vsync = 1'b0; blue2_in = 8'hFF; tick();
    blue2_in = 8'h3F; tick();
    chk("R4", "low bits ignored", {2'b00, ctl_e, ctl_f}, 4'h0);
    blue2_in = 8'h80; tick();
    chk("R4", "bit 7 to E", {2'b00, ctl_e, ctl_f}, 4'h2);
    blue2_in = 8'h40; tick();
    chk("R4", "bit 6 to F", {2'b00, ctl_e, ctl_f}, 4'h1);
    chk("R5", "lane 5 carries F", {2'b00, lane_ins_bits}, 4'h2);
    vsync = 1'b1; blue2_in = 8'hC0; tick();
    chk("R3", "hold after rise", {2'b00, ctl_e, ctl_f}, 4'h1);

    // R10: a vsync low pulse on gated cycles only is not seen
    pix_en = 1'b0; vsync = 1'b0; tick(); tick();
    vsync = 1'b1; tick();
    pix_en = 1'b1; tick();
    chk("R10", "gated pulse unseen", {2'b00, ctl_e, ctl_f}, 4'h1);

    // R9: asynchronous clear, then release with vsync already low
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", "async clear", {2'b00, ctl_e, ctl_f}, 4'h0);
    vsync = 1'b0; blue2_in = 8'hC0;
    tick();
    rst_n = 1'b1;
    tick(); tick();
    tick();
    chk("R9", "first low after reset is an edge", {2'b00, ctl_e, ctl_f}, 4'h0);
    tick();
    chk("R2", "capture after preset edge", {2'b00, ctl_e, ctl_f}, 4'h3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule